// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block lets a host reach a small bank of control and status registers over a synchronous serial link framed by an active-low chip select. The host sends an address byte first in every transaction. If the address names a control register, the host then sends one data byte, which is stored in that register. The reserved reset opcode clears the whole control bank and carries no data. Any other address starts a reply byte, which the block shifts out on a tri-state reply line. Control registers can only be written and status registers can only be read, so the two sets use separate address spaces.

The serial pins are brought into the system clock domain through synchronisers and then edge-detected, so the host's serial clock must run well below the system clock. Sticky status flags are set by one-cycle pulses from the surrounding logic. They are gated by the mask held in one of the control registers to drive an active-low, open-drain style interrupt. Reading the status register returns a snapshot of the flags and clears them.

Top module: `ctl_port_regbank`

## Requirements
- R1: Bits on `cmd_i` are taken on each rising serial-clock edge while `csn_i` is low, most significant bit first; a complete address byte followed by a complete data byte stores the data in the addressed control register.
- R2: Control registers answer at 0xE0, 0xE1, 0xE2, 0xE3, 0xE4, 0xE7, 0xE8 and 0xEE, and appear on `cfg_o` as slots 0 through 7 in that order, slot k on bits [8k+7:8k]; slot 7 (0xEE) is the interrupt mask.
- R3: The address byte 0x01 sets every control register to 0x00 at once, with no data byte.
- R4: Raising `csn_i` before a byte is complete discards that partial byte, and no control register changes.
- R5: `reply_oe_o` is high only during a reply byte. Reply bits come out most significant bit first, each valid while the serial clock is high, and `reply_o` changes only after a falling serial-clock edge.
- R6: Address 0xE5 replies with `rx_byte_i`. Address 0xE6 replies with the status flags, flag i on bit i. Any other address that is neither a control register nor 0x01 replies with 0x00, and a data byte sent during that reply changes no register.
- R7: A status read takes its snapshot when the address byte completes and clears the flags at that moment; a flag set pulse that arrives later in the same reply stays set.
- R8: `irq_no` is 0 when any flag is set whose mask bit is 1, and 1 (released) otherwise.
- R9: Once the second byte is complete, further serial bits are ignored until `csn_i` goes high.
- R10: After `rst_ni` every control register and flag is 0, `irq_no` is 1 and `reply_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, idle low |
| csn_i | input | 1 | Active-low transaction frame |
| cmd_i | input | 1 | Serial data from host |
| flag_set_i | input | 8 | One-cycle pulses that set the status flags |
| rx_byte_i | input | 8 | Value returned for the receive-data read address |
| reply_o | output | 1 | Serial reply data |
| reply_oe_o | output | 1 | Reply drive enable; low means high impedance |
| irq_no | output | 1 | Interrupt, 0 = pull low, 1 = released |
| cfg_o | output | 64 | Control register slots, packed |

## Verification
Directed writes to each of the eight control addresses, with distinct data, show whether the decode puts each byte into its own slot. Random mixes of writes, reads from unknown addresses, flag pulses and status reads are compared with a bench model, which tests the read-to-clear and masking behaviour in many orders. Transactions that are cut short after a few address or data bits show whether a partial transfer is discarded. Transactions padded with extra bits show whether the bank stops listening after its second byte. A flag pulse injected partway through a status reply shows whether the snapshot and the clear happen when the address byte completes.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int DW       = 8;
  localparam int NUM_WREG = 8;
  localparam int WIDX     = $clog2(NUM_WREG);
  localparam int CW       = $clog2(DW) + 1;
  localparam int MASK_SLOT = 7;

  localparam logic [DW-1:0] ADDR_RESET = 8'h01;
  localparam logic [DW-1:0] ADDR_RXB   = 8'hE5;
  localparam logic [DW-1:0] ADDR_STAT  = 8'hE6;

  typedef enum logic [1:0] {PH_ADDR, PH_WDATA, PH_REPLY, PH_DONE} phase_t;

  typedef struct packed {
    logic            hit;
    logic [WIDX-1:0] idx;
  } wsel_t;

  function automatic wsel_t wreg_lookup(input logic [DW-1:0] a);
    wsel_t s;
    s.hit = 1'b1;
    case (a)
      8'hE0:   s.idx = WIDX'(0);
      8'hE1:   s.idx = WIDX'(1);
      8'hE2:   s.idx = WIDX'(2);
      8'hE3:   s.idx = WIDX'(3);
      8'hE4:   s.idx = WIDX'(4);
      8'hE7:   s.idx = WIDX'(5);
      8'hE8:   s.idx = WIDX'(6);
      8'hEE:   s.idx = WIDX'(7);
      default: begin s.hit = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ctl_port_sync.sv
module ctl_port_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else          stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ctl_port_frame.sv
module ctl_port_frame
  import ctl_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          cmd_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [DW-1:0] addr_o,
  output logic          wr_stb_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rst_cmd_o,
  output logic          rd_req_o,
  output logic          reply_o,
  output logic          reply_oe_o
);
  phase_t        phase_q;
  logic [DW-1:0] in_sh, out_sh, in_next;
  logic [CW-1:0] cnt_q;
  logic          last_bit;

  assign in_next  = {in_sh[DW-2:0], cmd_i};
  assign last_bit = (cnt_q == CW'(DW-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_ADDR;
      in_sh     <= '0;
      out_sh    <= '0;
      cnt_q     <= '0;
      addr_o    <= '0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      rst_cmd_o <= 1'b0;
      rd_req_o  <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      rst_cmd_o <= 1'b0;
      rd_req_o  <= 1'b0;
      if (rd_req_o) out_sh <= rd_data_i;
      if (!cs_act_i) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (sclk_rise_i) begin
            in_sh <= in_next;
            if (last_bit) begin
              cnt_q  <= '0;
              addr_o <= in_next;
              if (in_next == ADDR_RESET) begin
                rst_cmd_o <= 1'b1;
                phase_q   <= PH_DONE;
              end else if (wreg_lookup(in_next).hit) begin
                phase_q <= PH_WDATA;
              end else begin
                rd_req_o <= 1'b1;
                phase_q  <= PH_REPLY;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_WDATA: if (sclk_rise_i) begin
            in_sh <= in_next;
            if (last_bit) begin
              wr_stb_o  <= 1'b1;
              wr_data_o <= in_next;
              phase_q   <= PH_DONE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_REPLY: begin
            // count host samples; advance the bit after each one is taken
            if (sclk_rise_i) cnt_q <= cnt_q + 1'b1;
            else if (sclk_fall_i) begin
              if (cnt_q == CW'(DW)) phase_q <= PH_DONE;
              else if (cnt_q != '0) out_sh <= {out_sh[DW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reply_oe_o = (phase_q == PH_REPLY);
  assign reply_o    = reply_oe_o ? out_sh[DW-1] : 1'b0;
endmodule

// File: rtl/ctl_port_wregs.sv
module ctl_port_wregs
  import ctl_port_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_stb_i,
  input  logic [DW-1:0]          addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   rst_cmd_i,
  output logic [NUM_WREG*DW-1:0] cfg_o
);
  wsel_t sel;
  assign sel = wreg_lookup(addr_i);

  for (genvar i = 0; i < NUM_WREG; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cfg_o[i*DW +: DW] <= '0;
      else if (rst_cmd_i) cfg_o[i*DW +: DW] <= '0;
      else if (wr_stb_i && sel.hit && (sel.idx == WIDX'(i)))
        cfg_o[i*DW +: DW] <= wr_data_i;
    end
  end
endmodule

// File: rtl/ctl_port_status.sv
module ctl_port_status
  import ctl_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic [DW-1:0] mask_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] flags_o,
  output logic          rd_clr_o,
  output logic          irq_no
);
  assign rd_clr_o = rd_req_i && (addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      irq_no  <= 1'b1;
    end else begin
      flags_o <= (rd_clr_o ? '0 : flags_o) | set_i;
      irq_no  <= ~|(flags_o & mask_i);
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_STAT: rd_data_o = flags_o;
      ADDR_RXB:  rd_data_o = rx_byte_i;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/ctl_port_regbank.sv
module ctl_port_regbank
  import ctl_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   csn_i,
  input  logic                   cmd_i,
  input  logic [DW-1:0]          flag_set_i,
  input  logic [DW-1:0]          rx_byte_i,
  output logic                   reply_o,
  output logic                   reply_oe_o,
  output logic                   irq_no,
  output logic [NUM_WREG*DW-1:0] cfg_o
);
  logic [2:0]    pins_s;
  logic          sclk_s, csn_s, cmd_s, sclk_d;
  logic          cs_act, sclk_rise, sclk_fall;
  logic [DW-1:0] addr, wr_data, rd_data, flags, mask;
  logic          wr_stb, rst_cmd, rd_req, rd_clr;

  ctl_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, csn_i, cmd_i}),
    .q_o   (pins_s)
  );
  assign {sclk_s, csn_s, cmd_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s;
  end

  assign cs_act    = !csn_s;
  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;

  ctl_port_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .cmd_i      (cmd_s),
    .rd_data_i  (rd_data),
    .addr_o     (addr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .rst_cmd_o  (rst_cmd),
    .rd_req_o   (rd_req),
    .reply_o    (reply_o),
    .reply_oe_o (reply_oe_o)
  );

  ctl_port_wregs u_wregs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .addr_i   (addr),
    .wr_data_i(wr_data),
    .rst_cmd_i(rst_cmd),
    .cfg_o    (cfg_o)
  );

  assign mask = cfg_o[MASK_SLOT*DW +: DW];

  ctl_port_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flag_set_i),
    .rd_req_i (rd_req),
    .addr_i   (addr),
    .rx_byte_i(rx_byte_i),
    .mask_i   (mask),
    .rd_data_o(rd_data),
    .flags_o  (flags),
    .rd_clr_o (rd_clr),
    .irq_no   (irq_no)
  );
endmodule

// File: rtl/ctl_port_regbank_chk.sv
module ctl_port_regbank_chk
  import ctl_port_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_act,
  input logic                   sclk_fall,
  input logic                   rd_req,
  input logic                   rst_cmd,
  input logic                   rd_clr,
  input logic [DW-1:0]          flags,
  input logic [DW-1:0]          flag_set_i,
  input logic [DW-1:0]          mask,
  input logic                   reply_o,
  input logic                   reply_oe_o,
  input logic                   irq_no,
  input logic [NUM_WREG*DW-1:0] cfg_o
);
  // R3
  reset_cmd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd |=> (cfg_o == '0));

  // R4
  idle_cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act && $past(!cs_act)) |=> $stable(cfg_o));

  // R5
  reply_off_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !reply_oe_o);

  // R5
  reply_moves_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reply_oe_o && $past(reply_oe_o) && !$past(sclk_fall) && !$past(rd_req))
      |-> $stable(reply_o));

  // R7
  status_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr |=> (flags == $past(flag_set_i)));

  // R8
  masked_irq_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> irq_no);
endmodule

bind ctl_port_regbank ctl_port_regbank_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act    (cs_act),
  .sclk_fall (sclk_fall),
  .rd_req    (rd_req),
  .rst_cmd   (rst_cmd),
  .rd_clr    (rd_clr),
  .flags     (flags),
  .flag_set_i(flag_set_i),
  .mask      (mask),
  .reply_o   (reply_o),
  .reply_oe_o(reply_oe_o),
  .irq_no    (irq_no),
  .cfg_o     (cfg_o)
);

// File: tb/ctl_port_regbank_tb.sv
module ctl_port_regbank_tb;
  localparam int HP = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, csn = 1'b1, cmd = 1'b0;
  logic [7:0]  fset = '0, rxb = '0;
  logic        reply, reply_oe, irq_n;
  logic [63:0] cfg;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_cfg [8];
  logic [7:0] exp_flags = '0;
  logic [7:0] waddr [8] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE7, 8'hE8, 8'hEE};

  always #5 clk = ~clk;

  ctl_port_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .cmd_i(cmd),
    .flag_set_i(fset), .rx_byte_i(rxb), .reply_o(reply), .reply_oe_o(reply_oe),
    .irq_no(irq_n), .cfg_o(cfg)
  );

  function automatic int wslot(input logic [7:0] a);
    for (int i = 0; i < 8; i++) if (waddr[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [63:0] pack_cfg();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_cfg[i];
    return v;
  endfunction

  function automatic logic exp_irq();
    return ~|(exp_flags & exp_cfg[7]);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r, output logic oe);
    cmd = b; cw(HP); sclk = 1'b1; cw(HP);
    r = reply; oe = reply_oe; sclk = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] v);
    fset = v; cw(1); fset = '0;
    exp_flags |= v;
  endtask

  // addr byte, then nd further bits (d MSB first, then extra ones); optional
  // flag pulse after the third following bit
  task automatic xact(input logic [7:0] a, input logic [7:0] d, input int nd,
                      input logic [7:0] late, output logic [7:0] rep,
                      output logic oe_all, output logic oe_any);
    logic r, oe;
    rep = '0; oe_all = 1'b1; oe_any = 1'b0;
    csn = 1'b0; cw(HP);
    for (int i = 7; i >= 0; i--) begin
      sbit(a[i], r, oe);
      oe_any |= oe;
    end
    for (int i = 0; i < nd; i++) begin
      sbit(i < 8 ? d[7-i] : 1'b1, r, oe);
      if (i < 8) begin rep[7-i] = r; oe_all &= oe; end
      oe_any |= oe;
      if (i == 2 && late != '0) pulse(late);
    end
    cw(HP); csn = 1'b1; cw(2*HP);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string req);
    logic [7:0] rep; logic oa, oy;
    xact(a, d, 8, '0, rep, oa, oy);
    if (wslot(a) >= 0) exp_cfg[wslot(a)] = d;
    chk({req, " cfg"}, cfg, pack_cfg());
    chk({req, " no reply drive"}, {63'd0, oy}, 64'd0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input logic [7:0] late,
                         input string req);
    logic [7:0] rep; logic oa, oy;
    xact(a, 8'hA5, 8, late, rep, oa, oy);
    chk({req, " reply"}, {56'd0, rep}, {56'd0, exp});
    chk({req, " oe during reply"}, {63'd0, oa}, 64'd1);
    chk({req, " oe after"}, {63'd0, reply_oe}, 64'd0);
    chk({req, " cfg unchanged"}, cfg, pack_cfg());
  endtask

  task automatic read_status(input logic [7:0] late, input string req);
    logic [7:0] snap;
    snap = exp_flags;
    exp_flags = '0;
    do_read(8'hE6, snap, late, req);
  endtask

  task automatic abort(input logic [7:0] a, input int nbits, input string req);
    logic r, oe;
    logic [15:0] s;
    s = {a, 8'h3C};
    csn = 1'b0; cw(HP);
    for (int i = 0; i < nbits; i++) sbit(s[15-i], r, oe);
    cw(HP); csn = 1'b1; cw(2*HP);
    chk({req, " cfg"}, cfg, pack_cfg());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rep, a, d;
    logic oa, oy;
    int sel;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 8; i++) exp_cfg[i] = '0;
    cw(4); rst_n = 1'b1; cw(4);

    // R10 reset state
    chk("R10 cfg", cfg, 64'd0);
    chk("R10 irq", {63'd0, irq_n}, 64'd1);
    chk("R10 oe", {63'd0, reply_oe}, 64'd0);

    // R1 R2 each slot with distinct data
    for (int i = 0; i < 8; i++) do_write(waddr[i], 8'h11 * (i + 1) ^ 8'h80, "R2");
    do_write(8'hE3, 8'b1000_0001, "R1 msb-first");
    do_write(8'hEE, 8'h00, "R1");

    // R6 rx byte, unknown addr, status
    rxb = 8'hC6;
    do_read(8'hE5, 8'hC6, '0, "R6 rx");
    do_read(8'hE9, 8'h00, '0, "R6 unknown");
    do_read(8'hE6, 8'h00, '0, "R6 status empty");

    // R8 masking
    pulse(8'h24); cw(4);
    chk("R8 masked off", {63'd0, irq_n}, {63'd0, exp_irq()});
    do_write(8'hEE, 8'h04, "R8 mask");
    chk("R8 asserted", {63'd0, irq_n}, {63'd0, exp_irq()});
    do_write(8'hEE, 8'h10, "R8 other mask");
    chk("R8 not matching", {63'd0, irq_n}, {63'd0, exp_irq()});

    // R7 snapshot then clear, late set survives
    do_write(8'hEE, 8'hFF, "R7 mask");
    read_status(8'h40, "R7 late set");
    cw(4);
    chk("R7 irq after read", {63'd0, irq_n}, {63'd0, exp_irq()});
    read_status('0, "R7 late flag kept");
    chk("R7 irq cleared", {63'd0, irq_n}, 64'd1);

    // R4 partial transfers
    abort(8'hE2, 5, "R4 mid address");
    abort(8'hE2, 12, "R4 mid data");
    abort(8'h01, 7, "R4 partial reset opcode");

    // R9 extra bits after data byte
    xact(8'hE1, 8'h5A, 20, '0, rep, oa, oy);
    exp_cfg[1] = 8'h5A;
    chk("R9 trailing bits", cfg, pack_cfg());

    // R3 reset opcode
    pulse(8'h01); cw(4);
    xact(8'h01, 8'h00, 0, '0, rep, oa, oy);
    for (int i = 0; i < 8; i++) exp_cfg[i] = '0;
    chk("R3 cfg cleared", cfg, 64'd0);
    chk("R3 irq released", {63'd0, irq_n}, {63'd0, exp_irq()});
    read_status('0, "R3 flags kept");

    // random mix
    for (int k = 0; k < 40; k++) begin
      sel = $urandom_range(0, 4);
      d = 8'($urandom);
      case (sel)
        0, 1: do_write(waddr[$urandom_range(0, 7)], d, "R1 R2 random write");
        2: begin
          a = 8'($urandom);
          if (wslot(a) >= 0 || a == 8'h01 || a == 8'hE5 || a == 8'hE6) a = 8'h55;
          do_read(a, 8'h00, '0, "R6 random unknown");
        end
        3: begin
          pulse(d); cw(4);
          chk("R8 random irq", {63'd0, irq_n}, {63'd0, exp_irq()});
        end
        default: read_status('0, "R7 random status");
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule